// File: doc/BRIEF.md
# Dual Timer/Counter with 32-bit Cascade

This block holds two 16-bit timer/counters, each a low byte and a high byte. Each channel counts either an internal tick or falling edges on its own external pin. The internal tick is a single-cycle pulse at one twelfth of the oscillator rate, made outside the block. A per-channel gate option lets a level input hold the channel off. A shared mode register gives each channel one of four counting arrangements. One control register holds the run bits, the two overflow flags and a cascade bit.

When the cascade bit is set, the two channels form one 32-bit counter. Channel 0 is the low half. Only a carry out of the top of channel 1 raises flag 1. Software reaches every register through one address/data port, and reads are combinational. The interrupt controller clears each flag with its own acknowledge strobe.

Top module: `twin_timer`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow outputs are low.
- R2: Register map at `addr`: 0 mode, 1 control, 2 channel-0 low byte, 3 channel-0 high byte, 4 channel-1 low byte, 5 channel-1 high byte. In the mode register, channel 0 uses bits [3:0] and channel 1 uses bits [7:4]; each nibble is {gate, clock-select, mode[1:0]}. The control register is {3'b0, cascade, flag1, flag0, run1, run0}. Every writable bit reads back as written.
- R3: Mode 01 is a 16-bit up-counter. Wrapping from 0xFFFF to 0x0000 sets that channel's flag.
- R4: Mode 00 is a 13-bit counter built from the high byte and low-byte bits [4:0]. Low-byte bits [7:5] keep their value. A wrap from all ones sets the flag.
- R5: Mode 10 counts the low byte. When the low byte is 0xFF, the next count loads it from the high byte and sets the flag.
- R6: Mode 11 on channel 0 splits it into two 8-bit counters. The low byte uses channel 0's enable and sets flag 0. The high byte counts internal ticks while run1 is 1 and sets flag 1. Channel 1 in mode 11 holds its count.
- R7: With clock-select 1, a channel counts falling edges of its pin, taken between two consecutive clock samples, and ignores the tick. With clock-select 0, it counts ticks.
- R8: With gate 1, a channel counts only while its gate pin is high. With gate 0, the gate pin has no effect.
- R9: With run 0, a channel holds its count.
- R10: With cascade 1, the channels form one 32-bit counter that ignores the mode fields. A carry out of bit 31 sets flag 1, and flag 0 is never set by a carry.
- R11: A write to a count byte in the same cycle as an increment stores the written value.
- R12: A carry sets its flag. Without a carry, a control write loads the flag bits; otherwise an acknowledge strobe clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| tick | input | 1 | Internal count pulse, one cycle wide |
| ext_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate level inputs, one per channel |
| ack | input | 2 | Flag clear strobes, one per flag |
| ovf | output | 2 | Overflow flags |

## Verification
The hardest states to reach are the 32-bit carry and the split-mode carries. Both need a counter sitting one count below a wrap while the right run and mode bits are set. The bench gets there by loading the count bytes directly, then enabling the run bits and issuing single tick pulses. Two contested cycles are also staged on purpose, each by driving both inputs in the same clock cycle: a tick arriving in the cycle of a count-byte write, and a carry arriving with an acknowledge.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int unsigned BW    = 8;
  localparam int unsigned PRE_W = 5;
  localparam int unsigned NCH   = 2;
  localparam int unsigned AW    = 3;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_C0L  = 3'd2;
  localparam logic [AW-1:0] A_C0H  = 3'd3;
  localparam logic [AW-1:0] A_C1L  = 3'd4;
  localparam logic [AW-1:0] A_C1H  = 3'd5;

  typedef enum logic [1:0] {
    MD_PRESC  = 2'b00,
    MD_WIDE   = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmode_e;

  typedef struct packed {
    logic [BW-1:0] lo;
    logic [BW-1:0] hi;
    logic          cy;
    logic          cy_hi;
  } step_t;

  // One increment step of a channel for the given arrangement.
  function automatic step_t cnt_step(tmode_e m, logic [BW-1:0] lo, logic [BW-1:0] hi,
                                     logic inc_lo, logic inc_hi);
    step_t r;
    logic [BW:0]     t9;
    logic [2*BW:0]   t17;
    r.lo = lo; r.hi = hi; r.cy = 1'b0; r.cy_hi = 1'b0;
    t9 = '0; t17 = '0;
    case (m)
      MD_PRESC: if (inc_lo) begin
        if (lo[PRE_W-1:0] == {PRE_W{1'b1}}) begin
          r.lo = {lo[BW-1:PRE_W], {PRE_W{1'b0}}};
          t9 = {1'b0, hi} + 1'b1;
          r.hi = t9[BW-1:0];
          r.cy = t9[BW];
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      MD_WIDE: if (inc_lo) begin
        t17 = {1'b0, hi, lo} + 1'b1;
        r.hi = t17[2*BW-1:BW];
        r.lo = t17[BW-1:0];
        r.cy = t17[2*BW];
      end
      MD_RELOAD: if (inc_lo) begin
        if (lo == {BW{1'b1}}) begin
          r.lo = hi;
          r.cy = 1'b1;
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      default: begin
        if (inc_lo) begin
          t9 = {1'b0, lo} + 1'b1;
          r.lo = t9[BW-1:0];
          r.cy = t9[BW];
        end
        if (inc_hi) begin
          t9 = {1'b0, hi} + 1'b1;
          r.hi = t9[BW-1:0];
          r.cy_hi = t9[BW];
        end
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic samp_q, prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= pin;
      prev_q <= samp_q;
    end
  end
  assign fall = prev_q & ~samp_q;
endmodule

// File: rtl/tmr_count_en.sv
module tmr_count_en (
  input  logic tick,
  input  logic fall,
  input  logic run,
  input  logic csel,
  input  logic gate_en,
  input  logic gate_pin,
  output logic en
);
  logic src, open;
  assign src  = csel ? fall : tick;
  assign open = run & (~gate_en | gate_pin);
  assign en   = src & open;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import twin_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  tmode_e        mode,
  input  logic          wide,
  input  logic          inc_lo,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic          cy,
  output logic          cy_hi
);
  step_t  nxt;
  tmode_e eff;
  logic   wr_any;

  assign eff    = wide ? MD_WIDE : mode;
  assign nxt    = cnt_step(eff, lo, hi, inc_lo, inc_hi);
  assign wr_any = wr_lo | wr_hi;
  assign cy     = nxt.cy & ~wr_any;
  assign cy_hi  = nxt.cy_hi & ~wr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : nxt.lo;
      hi <= wr_hi ? wdata : nxt.hi;
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  input  logic          tick,
  input  logic [NCH-1:0] ext_pin,
  input  logic [NCH-1:0] gate_pin,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] ovf
);
  logic [BW-1:0]  mode_q;
  logic [NCH-1:0] run_q;
  logic           casc_q;
  logic [NCH-1:0] fall, en, set_ovf;
  logic           wr_mode, wr_ctrl, wr_c0l, wr_c0h, wr_c1l, wr_c1h;
  logic [BW-1:0]  c0_lo, c0_hi, c1_lo, c1_hi;
  logic           cy0, cy0_hi, cy1, cy1_hi;
  logic           inc0_hi, inc1_lo;
  tmode_e         m0, m1;

  assign wr_mode = wr_en && addr == A_MODE;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_c0l  = wr_en && addr == A_C0L;
  assign wr_c0h  = wr_en && addr == A_C0H;
  assign wr_c1l  = wr_en && addr == A_C1L;
  assign wr_c1h  = wr_en && addr == A_C1H;

  assign m0 = tmode_e'(mode_q[1:0]);
  assign m1 = tmode_e'(mode_q[5:4]);

  for (genvar g = 0; g < NCH; g++) begin : g_src
    tmr_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin[g]), .fall(fall[g])
    );
    tmr_count_en u_en (
      .tick(tick), .fall(fall[g]), .run(run_q[g]),
      .csel(mode_q[4*g+2]), .gate_en(mode_q[4*g+3]),
      .gate_pin(gate_pin[g]), .en(en[g])
    );
  end

  assign inc0_hi = !casc_q && m0 == MD_SPLIT && tick && run_q[1];
  assign inc1_lo = casc_q ? cy0 : (m1 != MD_SPLIT && en[1]);

  tmr_chan u_ch0 (
    .clk(clk), .rst_n(rst_n), .mode(m0), .wide(casc_q),
    .inc_lo(en[0]), .inc_hi(inc0_hi), .wr_lo(wr_c0l), .wr_hi(wr_c0h),
    .wdata(wr_data), .lo(c0_lo), .hi(c0_hi), .cy(cy0), .cy_hi(cy0_hi)
  );
  tmr_chan u_ch1 (
    .clk(clk), .rst_n(rst_n), .mode(m1), .wide(casc_q),
    .inc_lo(inc1_lo), .inc_hi(1'b0), .wr_lo(wr_c1l), .wr_hi(wr_c1h),
    .wdata(wr_data), .lo(c1_lo), .hi(c1_hi), .cy(cy1), .cy_hi(cy1_hi)
  );

  assign set_ovf[0] = !casc_q && cy0;
  assign set_ovf[1] = casc_q ? cy1 : (m0 == MD_SPLIT ? cy0_hi : (cy1 | cy1_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_ctrl) begin
        run_q  <= wr_data[1:0];
        casc_q <= wr_data[4];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovf[g] <= 1'b0;
      else if (set_ovf[g]) ovf[g] <= 1'b1;
      else if (wr_ctrl)    ovf[g] <= wr_data[2+g];
      else if (ack[g])     ovf[g] <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_CTRL:  rd_data = {3'b000, casc_q, ovf, run_q};
      A_C0L:   rd_data = c0_lo;
      A_C0H:   rd_data = c0_hi;
      A_C1L:   rd_data = c1_lo;
      A_C1H:   rd_data = c1_hi;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] wr_data,
  input logic [1:0]    ovf,
  input logic [1:0]    ack,
  input logic [1:0]    set_ovf,
  input logic [1:0]    run_q,
  input logic          casc_q,
  input logic [BW-1:0] mode_q,
  input logic [1:0]    gate_pin,
  input logic [BW-1:0] c0_lo,
  input logic [BW-1:0] c0_hi,
  input logic [BW-1:0] c1_lo,
  input logic [BW-1:0] c1_hi
);
  logic wr_ctrl, wr_c0, wr_c1;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_c0   = wr_en && (addr == A_C0L || addr == A_C0H);
  assign wr_c1   = wr_en && (addr == A_C1L || addr == A_C1H);

  // R12
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf[0] |=> ovf[0]);
  // R12
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf[1] |=> ovf[1]);
  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack[0] && !set_ovf[0] && !wr_ctrl |=> !ovf[0]);
  // R10
  cascade_flag0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q && !wr_ctrl |=> !$rose(ovf[0]));
  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[0] && mode_q[1:0] != 2'b11 && !wr_c0 |=> $stable({c0_hi, c0_lo}));
  // R6
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5:4] == 2'b11 && !casc_q && !wr_c1 |=> $stable({c1_hi, c1_lo}));
  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3] && !gate_pin[0] && mode_q[1:0] != 2'b11 && !wr_c0 |=> $stable({c0_hi, c0_lo}));
  // R11
  write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_C0L |=> c0_lo == $past(wr_data));
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ovf(ovf), .ack(ack), .set_ovf(set_ovf), .run_q(run_q), .casc_q(casc_q),
  .mode_q(mode_q), .gate_pin(gate_pin),
  .c0_lo(c0_lo), .c0_hi(c0_hi), .c1_lo(c1_lo), .c1_hi(c1_hi)
);

// File: tb/twin_timer_bench.sv
module twin_timer_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [1:0] ext_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] ovf;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  twin_timer u_twin_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .ext_pin(ext_pin), .gate_pin(gate_pin),
    .ack(ack), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(a_lo, l);
    rd(a_lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [2:0] a_lo, input logic [15:0] v);
    wr(a_lo, v[7:0]);
    wr(a_lo + 3'd1, v[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      chk("R1 reset reg", {24'd0, d}, 32'h0);
    end
    chk("R1 reset ovf", {30'd0, ovf}, 32'h0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(3'd0, 8'hA5);
    rd(3'd0, d);
    chk("R2 mode readback", {24'd0, d}, 32'hA5);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h10);
    rd(3'd1, d);
    chk("R2 ctrl readback", {24'd0, d}, 32'h10);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_wide();
    logic [15:0] v;
    wr(3'd0, 8'h11);
    load(3'd2, 16'hFFFE);
    load(3'd4, 16'hFFFF);
    wr(3'd1, 8'h03);
    ticks(1);
    rd16(3'd2, v);
    chk("R3 ch0 count", {16'd0, v}, 32'hFFFF);
    chk("R3 ch1 wrap flag", {30'd0, ovf}, 32'h2);
    ticks(1);
    rd16(3'd2, v);
    chk("R3 ch0 wrap", {16'd0, v}, 32'h0000);
    chk("R3 both flags", {30'd0, ovf}, 32'h3);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_presc();
    logic [15:0] v;
    wr(3'd0, 8'h00);
    load(3'd2, 16'hFFFE);
    wr(3'd1, 8'h01);
    ticks(1);
    rd16(3'd2, v);
    chk("R4 13-bit step", {16'd0, v}, 32'hFFFF);
    chk("R4 no flag yet", {30'd0, ovf}, 32'h0);
    ticks(1);
    rd16(3'd2, v);
    chk("R4 wrap keeps lo[7:5]", {16'd0, v}, 32'h00E0);
    chk("R4 flag", {30'd0, ovf}, 32'h1);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    wr(3'd0, 8'h02);
    load(3'd2, 16'h80FF);
    wr(3'd1, 8'h01);
    ticks(1);
    rd16(3'd2, v);
    chk("R5 reload", {16'd0, v}, 32'h8080);
    chk("R5 flag", {30'd0, ovf}, 32'h1);
    ticks(1);
    rd16(3'd2, v);
    chk("R5 after reload", {16'd0, v}, 32'h8081);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_split();
    logic [15:0] v;
    wr(3'd0, 8'h33);
    load(3'd2, 16'hFFFF);
    load(3'd4, 16'h1234);
    wr(3'd1, 8'h01);
    ticks(1);
    rd16(3'd2, v);
    chk("R6 lo only", {16'd0, v}, 32'hFF00);
    chk("R6 flag0 from lo", {30'd0, ovf}, 32'h1);
    wr(3'd1, 8'h03);
    ticks(1);
    rd16(3'd2, v);
    chk("R6 hi counts with run1", {16'd0, v}, 32'h0001);
    chk("R6 flag1 from hi", {30'd0, ovf}, 32'h2);
    rd16(3'd4, v);
    chk("R6 ch1 held", {16'd0, v}, 32'h1234);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    wr(3'd0, 8'h05);
    load(3'd2, 16'h0000);
    wr(3'd1, 8'h01);
    ticks(2);
    rd16(3'd2, v);
    chk("R7 tick ignored", {16'd0, v}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_pin[0] = 1'b1;
      repeat (2) @(negedge clk);
      ext_pin[0] = 1'b0;
      repeat (3) @(negedge clk);
    end
    rd16(3'd2, v);
    chk("R7 three falls", {16'd0, v}, 32'h3);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    wr(3'd0, 8'h09);
    load(3'd2, 16'h0000);
    wr(3'd1, 8'h01);
    gate_pin[0] = 1'b0;
    ticks(3);
    rd16(3'd2, v);
    chk("R8 gate low holds", {16'd0, v}, 32'h0);
    gate_pin[0] = 1'b1;
    ticks(3);
    rd16(3'd2, v);
    chk("R8 gate high counts", {16'd0, v}, 32'h3);
    gate_pin[0] = 1'b0;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_run();
    logic [15:0] v;
    wr(3'd0, 8'h01);
    load(3'd2, 16'h0042);
    ticks(3);
    rd16(3'd2, v);
    chk("R9 run off holds", {16'd0, v}, 32'h0042);
  endtask

  task automatic t_cascade();
    logic [15:0] v;
    wr(3'd0, 8'h00);
    load(3'd2, 16'hFFFF);
    load(3'd4, 16'h0000);
    wr(3'd1, 8'h11);
    ticks(1);
    rd16(3'd2, v);
    chk("R10 low half wraps", {16'd0, v}, 32'h0);
    rd16(3'd4, v);
    chk("R10 carry into high half", {16'd0, v}, 32'h1);
    chk("R10 no flag mid", {30'd0, ovf}, 32'h0);
    load(3'd2, 16'hFFFF);
    load(3'd4, 16'hFFFF);
    ticks(1);
    rd16(3'd4, v);
    chk("R10 top wraps", {16'd0, v}, 32'h0);
    chk("R10 only flag1", {30'd0, ovf}, 32'h2);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_prio();
    logic [15:0] v;
    wr(3'd0, 8'h01);
    load(3'd2, 16'h0710);
    wr(3'd1, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd2; wr_data = 8'h55; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd16(3'd2, v);
    chk("R11 write beats increment", {16'd0, v}, 32'h0755);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_flags();
    wr(3'd1, 8'h0C);
    chk("R12 software set", {30'd0, ovf}, 32'h3);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    chk("R12 ack clears flag0", {30'd0, ovf}, 32'h2);
    wr(3'd1, 8'h00);
    chk("R12 software clear", {30'd0, ovf}, 32'h0);
    wr(3'd0, 8'h01);
    load(3'd2, 16'hFFFF);
    wr(3'd1, 8'h01);
    @(negedge clk); ack = 2'b01; tick = 1'b1;
    @(negedge clk); ack = 2'b00; tick = 1'b0;
    chk("R12 carry beats ack", {30'd0, ovf}, 32'h1);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_wide();
    t_presc();
    t_reload();
    t_split();
    t_ext();
    t_gate();
    t_run();
    t_cascade();
    t_prio();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule